// File: doc/BRIEF.md
# Seeded Pseudo-Random Register Block

This block is a polled, word-wide register peripheral that produces pseudo-random numbers. Software fills five 32-bit seed registers, writes the control register with the engine-select and start bits set, and then polls the status register until the generation-done bit appears. Five 32-bit output registers then hold the fresh values. Software clears done flags by writing zeros to the status register.

The engine is a 160-bit xorshift generator. Its state is made of five 32-bit words, x (word 0) through v (word 4). One step computes t = x ^ (x >> 2), shifts every word down one position, and sets the new v to (v ^ (v << 4)) ^ (t ^ (t << 1)). A run takes five steps, and the v of each step is stored in the next output register. The first run after any seed write loads the state from the seed registers. Later runs continue from where the previous run stopped.

Accesses use a one-cycle write strobe and a one-cycle read strobe. Read data is registered on the clock edge that samples the read strobe. Only full-word accesses exist.

Top module: `prng_mmio`

## Requirements
- R1: After reset the control register reads 0x0, status reads 0x01 (only bit 0, buffer ready, set), and all five output registers read 0.
- R2: Byte offsets are: control 0x000, status 0x010, seed n at 0x140+4n, output n at 0x160+4n (n = 0..4), in a 0x200-byte window. Reads of any other offset and of the seed registers return 0. Writes to other offsets and to the output registers change nothing.
- R3: Each seed register has a written flag cleared by reset. Status bit 1 reads 1 only once all five have been written since reset. Writing one seed several times does not count as more than one.
- R4: A control write stores the written value with bit 4 (start) forced to 0. A run starts only if status bit 1 is set, bit 3 (engine select) is written 1 and bit 4 is written 1.
- R5: Status bit 2 (busy) reads 1 from the edge that takes the start write until the fifth following edge. On that edge it clears and status bit 5 (done) sets, so five cycles after the start write the done flag is visible.
- R6: Output register k holds the v word produced by the (k+1)-th xorshift step of the run.
- R7: The first run after any seed write loads the state from the seeds, with an all-zero seed set replaced by words 0x9E3779B9 ^ n. A run with no seed write since the previous one continues from the previous state.
- R8: A status write sets bits 5, 4 and 3 to the written values. Bit 0 stays 1, bits 6 and 7 stay 0, and bits 1 and 2 keep following seed and busy state.
- R9: A control write that arrives while a run is busy stores its value with start cleared, but does not restart or extend the run.
- R10: When a status write lands in the same cycle a run completes, bit 5 ends up 1 and bits 4 and 3 take the written values.
- R11: Read data changes only on an edge where the read strobe is high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 9 | Byte offset within the register window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |

## Verification
Two events can fall in the same cycle: the engine finishing its fifth step, which sets the done bit, and a software status write, which replaces the done bit. The bench lines the write strobe up with the fifth edge after the start write, writing zero to done and ones to bits 4 and 3. It then judges the status word read afterwards against 0x3B. A second overlap, a fresh start write while a run is busy, is judged by the output words, which must match a single five-step run.

// File: rtl/prng_pkg.sv
package prng_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 5;
  localparam int ADDR_W    = 9;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  localparam logic [ADDR_W-1:0] OFF_CTRL = 9'h000;
  localparam logic [ADDR_W-1:0] OFF_STAT = 9'h010;
  localparam logic [ADDR_W-1:0] OFF_SEED = 9'h140;
  localparam logic [ADDR_W-1:0] OFF_OUT  = 9'h160;
  localparam logic [ADDR_W-3:0] WIN_WORDS = (ADDR_W-2)'(NUM_WORDS);

  // control bits
  localparam int CB_SEL = 3;
  localparam int CB_GO  = 4;
  // status bits
  localparam int SB_READY  = 0;
  localparam int SB_SEEDED = 1;
  localparam int SB_BUSY   = 2;
  localparam int SB_PART   = 3;
  localparam int SB_MSG    = 4;
  localparam int SB_DONE   = 5;

  localparam logic [DATA_W-1:0] ZERO_FIX = 32'h9E37_79B9;

  typedef logic [NUM_WORDS-1:0][DATA_W-1:0] wordVec_t;

  typedef struct packed {
    logic                 start;
    logic                 reload;
    logic [NUM_WORDS-1:0] seedWr;
  } ctrlStrobe_t;

  function automatic logic winHit(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] d;
    d = a - base;
    return (a >= base) && (d[1:0] == 2'b00) && (d[ADDR_W-1:2] < WIN_WORDS);
  endfunction

  function automatic logic [IDX_W-1:0] winIdx(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base);
    return IDX_W'((a - base) >> 2);
  endfunction

  function automatic logic isMapped(logic [ADDR_W-1:0] a);
    return (a == OFF_CTRL) || (a == OFF_STAT) || winHit(a, OFF_SEED) || winHit(a, OFF_OUT);
  endfunction

  function automatic wordVec_t zeroFix();
    wordVec_t r;
    for (int i = 0; i < NUM_WORDS; i++) r[i] = ZERO_FIX ^ DATA_W'(i);
    return r;
  endfunction

  function automatic wordVec_t xsStep(wordVec_t s);
    wordVec_t r;
    logic [DATA_W-1:0] t;
    t = s[0] ^ (s[0] >> 2);
    for (int i = 0; i < NUM_WORDS-1; i++) r[i] = s[i+1];
    r[NUM_WORDS-1] = (s[NUM_WORDS-1] ^ (s[NUM_WORDS-1] << 4)) ^ (t ^ (t << 1));
    return r;
  endfunction
endpackage

// File: rtl/prng_ctrl.sv
module prng_ctrl
  import prng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              running,
  input  logic              finishing,
  input  wordVec_t          outWords,
  output ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0]    ctrlQ;
  logic [NUM_WORDS-1:0] seedFlags;
  logic                 reloadQ;
  logic                 doneQ, msgQ, partQ;
  logic                 seeded;
  logic                 ctrlWr, statWr;
  logic [NUM_WORDS-1:0] seedWrVec;
  logic [DATA_W-1:0]    statWord, rdMux;

  assign ctrlWr = wrEn && (addr == OFF_CTRL);
  assign statWr = wrEn && (addr == OFF_STAT);
  assign seeded = &seedFlags;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_seedDec
    assign seedWrVec[i] = wrEn && winHit(addr, OFF_SEED) && (winIdx(addr, OFF_SEED) == IDX_W'(i));
  end

  always_comb begin
    strobe.seedWr = seedWrVec;
    strobe.reload = reloadQ;
    strobe.start  = ctrlWr && seeded && wrData[CB_SEL] && wrData[CB_GO] && !running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      seedFlags <= '0;
      reloadQ   <= 1'b1;
      doneQ     <= 1'b0;
      msgQ      <= 1'b0;
      partQ     <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ctrlQ         <= wrData;
        ctrlQ[CB_GO]  <= 1'b0;
      end
      seedFlags <= seedFlags | seedWrVec;
      if (|seedWrVec)        reloadQ <= 1'b1;
      else if (strobe.start) reloadQ <= 1'b0;
      if (statWr) begin
        msgQ  <= wrData[SB_MSG];
        partQ <= wrData[SB_PART];
      end
      if (finishing)   doneQ <= 1'b1;
      else if (statWr) doneQ <= wrData[SB_DONE];
    end
  end

  always_comb begin
    statWord            = '0;
    statWord[SB_READY]  = 1'b1;
    statWord[SB_SEEDED] = seeded;
    statWord[SB_BUSY]   = running;
    statWord[SB_PART]   = partQ;
    statWord[SB_MSG]    = msgQ;
    statWord[SB_DONE]   = doneQ;
  end

  always_comb begin
    rdMux = '0;
    if (addr == OFF_CTRL)         rdMux = ctrlQ;
    else if (addr == OFF_STAT)    rdMux = statWord;
    else if (winHit(addr, OFF_OUT)) rdMux = outWords[winIdx(addr, OFF_OUT)];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end
endmodule

// File: rtl/prng_datapath.sv
module prng_datapath
  import prng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output wordVec_t          outWords,
  output logic              running,
  output logic              finishing
);
  logic [DATA_W-1:0] seedQ [NUM_WORDS];
  wordVec_t          seedVec, loadVal, stateQ, stateNext, outQ;
  logic [IDX_W-1:0]  cntQ;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_seed
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 seedQ[i] <= '0;
      else if (strobe.seedWr[i]) seedQ[i] <= wrData;
    end
    assign seedVec[i] = seedQ[i];
  end

  assign loadVal   = (seedVec == '0) ? zeroFix() : seedVec;
  assign stateNext = xsStep(stateQ);
  assign finishing = running && (cntQ == IDX_W'(NUM_WORDS-1));
  assign outWords  = outQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= '0;
      outQ    <= '0;
      cntQ    <= '0;
      running <= 1'b0;
    end else if (strobe.start) begin
      running <= 1'b1;
      cntQ    <= '0;
      if (strobe.reload) stateQ <= loadVal;
    end else if (running) begin
      stateQ     <= stateNext;
      outQ[cntQ] <= stateNext[NUM_WORDS-1];
      cntQ       <= cntQ + 1'b1;
      if (finishing) running <= 1'b0;
    end
  end
endmodule

// File: rtl/prng_mmio.sv
module prng_mmio
  import prng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  ctrlStrobe_t strobe;
  wordVec_t    outWords;
  logic        running, finishing;

  prng_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .running(running), .finishing(finishing),
    .outWords(outWords), .strobe(strobe), .rdData(rdData)
  );

  prng_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .outWords(outWords), .running(running), .finishing(finishing)
  );
endmodule

// File: rtl/prng_mmio_chk.sv
module prng_mmio_chk
  import prng_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        wrSelGo,
  input logic [DATA_W-1:0] rdData,
  input logic              running,
  input logic              finishing
);
  AST_CTRL_GO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == OFF_CTRL) |=> (rdData[CB_GO] == 1'b0)); // R4

  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(wrEn && addr == OFF_CTRL && wrSelGo == 2'b11)); // R4

  AST_STAT_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == OFF_STAT) |=> (rdData[SB_READY] && !rdData[6] && !rdData[7])); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (!isMapped(addr) || winHit(addr, OFF_SEED))) |=> (rdData == '0)); // R2

  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    finishing |=> !running); // R5

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R11
endmodule

bind prng_mmio prng_mmio_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrSelGo(wrData[4:3]), .rdData(rdData), .running(running), .finishing(finishing)
);

// File: tb/prng_mmio_bench.sv
`timescale 1ns/1ps
module prng_mmio_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prng_mmio u_prng_mmio (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  // vector: {isWrite, req, addr, data/expected}
  localparam int NV = 30;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 8'd1, 9'h000, 32'h0000_0000},  // R1 control reset
    {1'b0, 8'd1, 9'h010, 32'h0000_0001},  // R1 status reset
    {1'b0, 8'd1, 9'h160, 32'h0000_0000},  // R1 output 0 reset
    {1'b0, 8'd1, 9'h170, 32'h0000_0000},  // R1 output 4 reset
    {1'b1, 8'd4, 9'h000, 32'h0000_0008},
    {1'b0, 8'd4, 9'h000, 32'h0000_0008},  // R4 control stored
    {1'b1, 8'd4, 9'h000, 32'h0000_0018},
    {1'b0, 8'd4, 9'h000, 32'h0000_0008},  // R4 start cleared
    {1'b0, 8'd4, 9'h010, 32'h0000_0001},  // R4 no run without seeds
    {1'b1, 8'd3, 9'h140, 32'hDEAD_BEEF},
    {1'b1, 8'd3, 9'h144, 32'h0123_4567},
    {1'b1, 8'd3, 9'h148, 32'h89AB_CDEF},
    {1'b1, 8'd3, 9'h14C, 32'h0F1E_2D3C},
    {1'b1, 8'd3, 9'h140, 32'hDEAD_BEEF},
    {1'b0, 8'd3, 9'h010, 32'h0000_0001},  // R3 four distinct seeds
    {1'b1, 8'd3, 9'h150, 32'hA5A5_A5A5},
    {1'b0, 8'd3, 9'h010, 32'h0000_0003},  // R3 all seeds
    {1'b0, 8'd2, 9'h140, 32'h0000_0000},  // R2 seed reads zero
    {1'b1, 8'd2, 9'h164, 32'hFFFF_FFFF},
    {1'b0, 8'd2, 9'h164, 32'h0000_0000},  // R2 output write ignored
    {1'b1, 8'd2, 9'h1FC, 32'h1234_5678},
    {1'b0, 8'd2, 9'h1FC, 32'h0000_0000},  // R2 unmapped
    {1'b1, 8'd4, 9'h000, 32'h0000_0010},
    {1'b0, 8'd4, 9'h000, 32'h0000_0000},  // R4 start alone cleared
    {1'b0, 8'd4, 9'h010, 32'h0000_0003},  // R4 no run without select
    {1'b1, 8'd8, 9'h010, 32'hFFFF_FFFF},
    {1'b0, 8'd8, 9'h010, 32'h0000_003B},  // R8 writable bits set
    {1'b1, 8'd8, 9'h010, 32'h0000_0000},
    {1'b0, 8'd8, 9'h010, 32'h0000_0003},  // R8 cleared by zeros
    {1'b0, 8'd2, 9'h004, 32'h0000_0000}   // R2 gap offset
  };

  // independent model of the engine
  logic [31:0] mSeed [5] = '{32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'h0F1E_2D3C, 32'hA5A5_A5A5};
  logic [31:0] mState [5];
  logic [31:0] mOut [5];
  logic        mReload = 1'b1;

  task automatic modelRun();
    logic [31:0] t;
    logic        allZero;
    if (mReload) begin
      allZero = 1'b1;
      for (int i = 0; i < 5; i++) if (mSeed[i] != 0) allZero = 1'b0;
      for (int i = 0; i < 5; i++) mState[i] = allZero ? (32'h9E37_79B9 ^ i) : mSeed[i];
      mReload = 1'b0;
    end
    for (int k = 0; k < 5; k++) begin
      t = mState[0] ^ (mState[0] >> 2);
      mState[0] = mState[1];
      mState[1] = mState[2];
      mState[2] = mState[3];
      mState[3] = mState[4];
      mState[4] = (mState[4] ^ (mState[4] << 4)) ^ (t ^ (t << 1));
      mOut[k] = mState[4];
    end
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic checkOutputs(input string req);
    logic [31:0] v;
    for (int k = 0; k < 5; k++) begin
      rd(9'h160 + 9'(4*k), v);
      check(v, mOut[k], req);
    end
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][49]) wr(VEC[i][40:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][40:32], v);
        check(v, VEC[i][31:0], $sformatf("R%0d vector %0d", VEC[i][48:41], i));
      end
    end

    // R5 R6 first run from seeds
    wr(9'h000, 32'h18);
    modelRun();
    rd(9'h010, v);
    check(v, 32'h07, "R5 busy during run");
    repeat (6) @(negedge clk);
    rd(9'h010, v);
    check(v, 32'h23, "R5 done after run");
    rd(9'h000, v);
    check(v, 32'h08, "R4 start cleared after run");
    checkOutputs("R6 outputs of first run");

    // R7 second run continues from state
    wr(9'h010, 32'h0);
    wr(9'h000, 32'h18);
    modelRun();
    repeat (7) @(negedge clk);
    rd(9'h010, v);
    check(v, 32'h23, "R7 second run done");
    checkOutputs("R7 continued state");

    // R9 start while busy is not a restart
    wr(9'h010, 32'h0);
    wr(9'h000, 32'h18);
    modelRun();
    wr(9'h000, 32'h1F);
    repeat (6) @(negedge clk);
    rd(9'h000, v);
    check(v, 32'h0F, "R9 value stored with start cleared");
    rd(9'h010, v);
    check(v, 32'h23, "R9 status after overlapped start");
    checkOutputs("R9 single run only");

    // R10 status write on completion edge
    wr(9'h010, 32'h0);
    wr(9'h000, 32'h18);
    modelRun();
    repeat (3) @(negedge clk);
    wr(9'h010, 32'h18);
    repeat (2) @(negedge clk);
    rd(9'h010, v);
    check(v, 32'h3B, "R10 done wins over cleared write");
    checkOutputs("R10 outputs");

    // R7 all-zero seeds replaced by fixed words
    for (int i = 0; i < 5; i++) begin
      wr(9'h140 + 9'(4*i), 32'h0);
      mSeed[i] = 32'h0;
    end
    mReload = 1'b1;
    wr(9'h010, 32'h0);
    wr(9'h000, 32'h18);
    modelRun();
    repeat (7) @(negedge clk);
    checkOutputs("R7 zero seed substitution");

    // R11 read data holds without read strobe
    rd(9'h168, held);
    check(held, mOut[2], "R11 read value");
    repeat (4) @(negedge clk);
    check(rdData, held, "R11 held without strobe");
    rd(9'h14C, v);
    check(v, 32'h0, "R2 seed read after run");

    // R1 reset again clears outputs
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rd(9'h160, v);
    check(v, 32'h0, "R1 outputs after reset");
    rd(9'h010, v);
    check(v, 32'h01, "R3 flags cleared by reset");

    finish();
  end
endmodule